// File: doc/BRIEF.md
# Interrupt Capture and Replay Controller

This block sits between a set of external interrupt lines and a downstream interrupt controller. It watches every line all the time and keeps a per-line "recorded" bit, so that an interrupt that arrives while the downstream controller is powered down or idle is kept. Later, software issues a flush command, and the block replays each recorded line to the downstream controller as a single-cycle pulse.

Each line has a mask bit, a sensitivity bit (edge or level) and a polarity bit. Software sets these through write-one-to-set and write-one-to-clear register banks on a 32-bit memory-mapped port, with lines packed 32 to a word. An acknowledge bank clears recorded bits. A control register holds an enable bit, an edge-only recording mode bit and the flush command. The number of lines is a parameter (default 64).

Top module: `irq_replay`

## Requirements
- R1: Line n maps to bit (n mod 32) of the word at bank base + 4*(n div 32). Bank bases: 0x0C0 mask set, 0x100 mask clear, 0x180 sensitivity set, 0x1C0 sensitivity clear, 0x240 polarity set, 0x280 polarity clear, 0x040 acknowledge. The control word is at 0x300.
- R2: In a set bank, a 1 bit sets that line's bit. In a clear bank, a 1 bit clears it. A 0 bit changes nothing.
- R3: A read of an acknowledge word returns the recorded-status word. A read of a set-bank word returns the mask, sensitivity or polarity word. A read of the control word returns enable in bit 0, edge-only in bit 1 and flush-in-progress in bit 2. Every other address reads 0. After reset, all registers, recorded bits and replay outputs are 0.
- R4: When a line's sensitivity bit is 0, the line is recorded on its active edge. When the bit is 1, the line is recorded in every cycle it sits at its active level. Polarity 1 selects the rising edge or the high level. Polarity 0 selects the falling edge or the low level.
- R5: A line whose mask bit is 1 never becomes recorded.
- R6: With edge-only mode on (control bit 1), a level-sensitive line is recorded only on its transition into the active level.
- R7: Recording takes place whatever the value of the enable bit (control bit 0).
- R8: Writing 1 to an acknowledge bit clears that recorded bit. A line that has an event in the same cycle stays recorded.
- R9: A control write with bit 2 and bit 0 both set starts a flush. The flush scans lines in ascending order, one line per cycle. It emits a one-cycle pulse on `replay_out` for each recorded line, never more than one line at a time, and clears each recorded bit as that line is replayed.
- R10: The flush bit reads 1 while the scan runs. It returns to 0 after NUM_LINES cycles. A flush write with bit 0 clear is ignored: no pulses, and the recorded bits are kept.
- R11: Inputs pass through a two-flop synchronizer. An input change is first visible in the recorded status after the third rising clock edge following it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | NUM_LINES | Asynchronous external interrupt lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Byte address of the register word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| replay_out | output | NUM_LINES | Replay pulses toward the downstream controller |

## Verification
The assertions assume the following about the inputs:
- Register writes hold a word-aligned address for one cycle.
- Reset is held for at least one clock so that the history used by `$past` starts from the reset values.
- `irq_in` may change at any time. The checks look only at synchronized state, so asynchronous timing is never in question.

The bench follows these rules. It drives writes and input changes on the falling edge and pulses the write strobe for exactly one cycle. It holds reset for several cycles. It waits long enough after every input change for the synchronizer and the recording stage to settle before it reads status back.

// File: rtl/irq_replay_pkg.sv
// Package: register offsets and control-bit positions shared by the
// capture-and-replay controller and its checker.
package irq_replay_pkg;
    localparam int unsigned OFS_ACK  = 32'h040;
    localparam int unsigned OFS_MSET = 32'h0C0;
    localparam int unsigned OFS_MCLR = 32'h100;
    localparam int unsigned OFS_SSET = 32'h180;
    localparam int unsigned OFS_SCLR = 32'h1C0;
    localparam int unsigned OFS_PSET = 32'h240;
    localparam int unsigned OFS_PCLR = 32'h280;
    localparam int unsigned OFS_CTRL = 32'h300;

    localparam int CTL_EN = 0;   // enable
    localparam int CTL_EO = 1;   // edge-only recording
    localparam int CTL_FL = 2;   // flush command / busy
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// Two-flop synchronizer for a vector of asynchronous lines, followed by one
// history flop so that later stages can compare current and previous values.
// Assumes each line is an independent level. No bus-coherency is implied.
module irq_sync #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] cur,
    output logic [WIDTH-1:0] prev
);
    logic [WIDTH-1:0] meta;

    // Purpose: bring lines into the clock domain and keep one cycle of history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            cur  <= '0;
            prev <= '0;
        end else begin
            meta <= async_in;
            cur  <= meta;
            prev <= cur;
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Module: irq_cfg_regs
// Holds the per-line mask, sensitivity and polarity banks, which are changed
// through write-one-to-set and write-one-to-clear words. Also holds the
// control bits. Decodes acknowledge writes into a per-line clear vector and
// flush writes into a start pulse. Assumes word-aligned single-cycle writes.
// Bits above NUM_LINES in the last word stay at 0.
module irq_cfg_regs
    import irq_replay_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12,
    parameter int WORDS     = (NUM_LINES + 31) / 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic [WORDS*32-1:0]   mask_w,
    output logic [WORDS*32-1:0]   sens_w,
    output logic [WORDS*32-1:0]   pol_w,
    output logic [NUM_LINES-1:0]  ack_clr,
    output logic                  enable,
    output logic                  edge_only,
    output logic                  flush_req
);
    localparam int PAD = WORDS * 32;

    logic [PAD-1:0] ack_pad;
    logic           hit_ctl;

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        localparam int REM = NUM_LINES - 32 * w;
        localparam logic [31:0] VLD = (REM >= 32) ? 32'hFFFF_FFFF
                                                  : ((32'd1 << REM) - 32'd1);
        logic hit_ms, hit_mc, hit_ss, hit_sc, hit_ps, hit_pc, hit_ack;

        assign hit_ms  = wr && (addr == ADDR_W'(OFS_MSET + 4 * w));
        assign hit_mc  = wr && (addr == ADDR_W'(OFS_MCLR + 4 * w));
        assign hit_ss  = wr && (addr == ADDR_W'(OFS_SSET + 4 * w));
        assign hit_sc  = wr && (addr == ADDR_W'(OFS_SCLR + 4 * w));
        assign hit_ps  = wr && (addr == ADDR_W'(OFS_PSET + 4 * w));
        assign hit_pc  = wr && (addr == ADDR_W'(OFS_PCLR + 4 * w));
        assign hit_ack = wr && (addr == ADDR_W'(OFS_ACK + 4 * w));

        assign ack_pad[w*32 +: 32] = hit_ack ? (wdata & VLD) : 32'd0;

        // Purpose: apply set/clear writes to this word of the three banks.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_w[w*32 +: 32] <= '0;
                sens_w[w*32 +: 32] <= '0;
                pol_w[w*32 +: 32]  <= '0;
            end else begin
                if (hit_ms) mask_w[w*32 +: 32] <= mask_w[w*32 +: 32] | (wdata & VLD);
                if (hit_mc) mask_w[w*32 +: 32] <= mask_w[w*32 +: 32] & ~wdata;
                if (hit_ss) sens_w[w*32 +: 32] <= sens_w[w*32 +: 32] | (wdata & VLD);
                if (hit_sc) sens_w[w*32 +: 32] <= sens_w[w*32 +: 32] & ~wdata;
                if (hit_ps) pol_w[w*32 +: 32]  <= pol_w[w*32 +: 32] | (wdata & VLD);
                if (hit_pc) pol_w[w*32 +: 32]  <= pol_w[w*32 +: 32] & ~wdata;
            end
        end
    end

    assign ack_clr   = ack_pad[NUM_LINES-1:0];
    assign hit_ctl   = wr && (addr == ADDR_W'(OFS_CTRL));
    assign flush_req = hit_ctl && wdata[CTL_FL] && wdata[CTL_EN];

    // Purpose: hold the enable and edge-only control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable    <= 1'b0;
            edge_only <= 1'b0;
        end else if (hit_ctl) begin
            enable    <= wdata[CTL_EN];
            edge_only <= wdata[CTL_EO];
        end
    end
endmodule

// File: rtl/irq_capture.sv
// Module: irq_capture
// Turns synchronized lines into per-line events according to mask,
// sensitivity, polarity and edge-only mode, and keeps the recorded-status
// bits. Recording does not depend on the enable bit. A new event wins over
// a clear that arrives in the same cycle, so no event is lost.
module irq_capture #(
    parameter int NUM_LINES = 64
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] cur,
    input  logic [NUM_LINES-1:0] prev,
    input  logic [NUM_LINES-1:0] mask,
    input  logic [NUM_LINES-1:0] sens,
    input  logic [NUM_LINES-1:0] pol,
    input  logic                 edge_only,
    input  logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] status
);
    logic [NUM_LINES-1:0] act, act_prev, into_act, lvl_mode, event_v;

    // Purpose: form per-line events from the current line configuration.
    always_comb begin
        act      = ~(cur ^ pol);
        act_prev = ~(prev ^ pol);
        into_act = act & ~act_prev;
        lvl_mode = sens & {NUM_LINES{~edge_only}};
        event_v  = ~mask & ((lvl_mode & act) | (~lvl_mode & into_act));
    end

    // Purpose: hold recorded status, clearing on ack or replay and setting on events.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr) | event_v;
    end
endmodule

// File: rtl/irq_flush.sv
// Module: irq_flush
// Flush sequencer. On a start pulse it walks line indices 0..NUM_LINES-1,
// one per cycle. For every recorded line it asks for that status bit to be
// cleared and sends a registered one-cycle pulse on the replay output.
// A start that arrives during a scan is ignored.
module irq_flush #(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [NUM_LINES-1:0] status,
    output logic                 busy,
    output logic [NUM_LINES-1:0] clr,
    output logic [NUM_LINES-1:0] replay
);
    logic [IDX_W-1:0] idx;

    // Purpose: select the status bit under the scan pointer for replay.
    always_comb begin
        clr = '0;
        if (busy && status[idx]) clr[idx] = 1'b1;
    end

    // Purpose: advance the scan pointer and register the replay pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            idx    <= '0;
            replay <= '0;
        end else begin
            replay <= clr;
            if (busy) begin
                if (idx == IDX_W'(NUM_LINES - 1)) busy <= 1'b0;
                idx <= idx + 1'b1;
            end else if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end
        end
    end
endmodule

// File: rtl/irq_replay.sv
// Module: irq_replay (top)
// Interrupt capture and replay controller. It records events on external
// lines at all times and replays them as pulses on a flush command. Reads
// are combinational from bus_addr. Assumes word-aligned addresses and
// NUM_LINES small enough that each bank fits below the next bank's base.
module irq_replay
    import irq_replay_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NUM_LINES-1:0] replay_out
);
    localparam int WORDS = (NUM_LINES + 31) / 32;
    localparam int PAD   = WORDS * 32;

    logic [NUM_LINES-1:0] sync_cur, sync_prev, ack_clr, flush_clr, rec_status;
    logic [NUM_LINES-1:0] mask_lines;
    logic [PAD-1:0]       mask_w, sens_w, pol_w, status_pad;
    logic                 enable, edge_only, flush_req, flush_busy;

    irq_sync #(.WIDTH(NUM_LINES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(irq_in),
        .cur(sync_cur), .prev(sync_prev)
    );

    irq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .WORDS(WORDS)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .mask_w(mask_w), .sens_w(sens_w), .pol_w(pol_w), .ack_clr(ack_clr),
        .enable(enable), .edge_only(edge_only), .flush_req(flush_req)
    );

    assign mask_lines = mask_w[NUM_LINES-1:0];

    irq_capture #(.NUM_LINES(NUM_LINES)) u_cap (
        .clk(clk), .rst_n(rst_n), .cur(sync_cur), .prev(sync_prev),
        .mask(mask_lines), .sens(sens_w[NUM_LINES-1:0]), .pol(pol_w[NUM_LINES-1:0]),
        .edge_only(edge_only), .clr(ack_clr | flush_clr), .status(rec_status)
    );

    irq_flush #(.NUM_LINES(NUM_LINES)) u_flush (
        .clk(clk), .rst_n(rst_n), .start(flush_req), .status(rec_status),
        .busy(flush_busy), .clr(flush_clr), .replay(replay_out)
    );

    assign status_pad = PAD'(rec_status);

    // Purpose: return the word selected by bus_addr.
    always_comb begin
        bus_rdata = 32'd0;
        for (int w = 0; w < WORDS; w++) begin
            if (bus_addr == ADDR_W'(OFS_ACK + 4 * w))  bus_rdata = status_pad[w*32 +: 32];
            if (bus_addr == ADDR_W'(OFS_MSET + 4 * w)) bus_rdata = mask_w[w*32 +: 32];
            if (bus_addr == ADDR_W'(OFS_SSET + 4 * w)) bus_rdata = sens_w[w*32 +: 32];
            if (bus_addr == ADDR_W'(OFS_PSET + 4 * w)) bus_rdata = pol_w[w*32 +: 32];
        end
        if (bus_addr == ADDR_W'(OFS_CTRL))
            bus_rdata = {29'd0, flush_busy, edge_only, enable};
    end
endmodule

// File: rtl/irq_replay_chk.sv
// Module: irq_replay_chk
// Concurrent checks on the capture-and-replay controller, attached through
// bind. Inputs are top-level ports plus recorded status, mask and flush busy.
module irq_replay_chk
    import irq_replay_pkg::*;
#(
    parameter int NUM_LINES = 64,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_wr,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [31:0]          bus_wdata,
    input logic [NUM_LINES-1:0] replay_out,
    input logic [NUM_LINES-1:0] status,
    input logic [NUM_LINES-1:0] mask,
    input logic                 busy
);
    // R9: at most one line replayed per cycle
    p_single_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(replay_out));

    // R9: a replay pulse lasts one cycle
    p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|replay_out) |=> ((replay_out & $past(replay_out)) == '0));

    // R9: only recorded lines are replayed
    p_replay_recorded_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|replay_out) |-> (($past(status) & replay_out) == replay_out));

    // R5: masked lines never become recorded
    p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((status & ~$past(status) & $past(mask)) == '0));

    // R10: flush write without enable does not start a scan
    p_flush_needs_en_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_CTRL) && bus_wdata[CTL_FL]
         && !bus_wdata[CTL_EN] && !busy) |=> !busy);
endmodule

bind irq_replay irq_replay_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .replay_out(replay_out), .status(rec_status),
    .mask(mask_lines), .busy(flush_busy)
);

// File: tb/test_irq_replay.sv
module test_irq_replay;
    localparam int N  = 64;
    localparam int AW = 12;
    localparam int L  = 5;   // line used by the vector table

    // {sens, pol, mask, edge_only, start level, end level, expected recorded}
    // The whole table runs with enable = 0 (R7).
    localparam logic [6:0] VEC [12] = '{
        7'b0100011,  // R4 edge rising 0->1
        7'b0100100,  // R4 edge rising 1->0
        7'b0000101,  // R4 edge falling 1->0
        7'b0000010,  // R4 edge falling 0->1
        7'b1100111,  // R4 R8 level high held, re-records after ack
        7'b1101110,  // R6 level high held, edge-only
        7'b1101011,  // R6 level high rising, edge-only
        7'b1000001,  // R4 level low held
        7'b1000110,  // R4 level low, line high
        7'b0110010,  // R5 masked edge
        7'b1110110,  // R5 masked level
        7'b0100011   // R7 edge rising again, still disabled
    };

    logic          clk = 0, rst_n = 0, bus_wr = 0;
    logic [N-1:0]  irq_in = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0, bus_rdata, d;
    logic [N-1:0]  replay_out;
    int checks = 0, errors = 0, pulse_cnt = 0, multi = 0;
    int pulse_log [16];
    bit done = 0;

    always #2 clk = ~clk;

    irq_replay #(.NUM_LINES(N), .ADDR_W(AW)) i_irq_replay (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .replay_out(replay_out)
    );

    // Collect replay pulses away from the active edge.
    always @(negedge clk) begin
        if (rst_n && replay_out != '0) begin
            if ($countones(replay_out) > 1) multi++;
            for (int i = 0; i < N; i++)
                if (replay_out[i]) begin
                    if (pulse_cnt < 16) pulse_log[pulse_cnt] = i;
                    pulse_cnt++;
                end
        end
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] v);
        @(negedge clk);
        bus_wr = 1; bus_addr = AW'(a); bus_wdata = v;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = AW'(a);
        #1 v = bus_rdata;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_all();
        wr('h040, 32'hFFFF_FFFF);
        wr('h044, 32'hFFFF_FFFF);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        waitc(4);
        rst_n = 1;
        // R3 reset state
        rd('h0C0, d); chk("R3 reset mask", d, 0);
        rd('h180, d); chk("R3 reset sens", d, 0);
        rd('h244, d); chk("R3 reset pol", d, 0);
        rd('h040, d); chk("R3 reset status", d, 0);
        rd('h300, d); chk("R3 reset ctrl", d, 0);
        chk("R3 reset replay", replay_out[31:0], 0);

        // Vector table on line L
        foreach (VEC[k]) begin
            wr('h300, {30'd0, VEC[k][3], 1'b0});
            wr(VEC[k][6] ? 'h180 : 'h1C0, 32'd1 << L);
            wr(VEC[k][5] ? 'h240 : 'h280, 32'd1 << L);
            wr(VEC[k][4] ? 'h0C0 : 'h100, 32'd1 << L);
            irq_in[L] = VEC[k][2];
            waitc(6);
            wr('h040, 32'd1 << L);
            irq_in[L] = VEC[k][1];
            waitc(6);
            rd('h040, d);
            chk($sformatf("R4 R5 R6 R7 vector %0d", k), 32'(d[L]), 32'(VEC[k][0]));
        end

        // R2 set/clear, zeros leave bits alone
        wr('h100, 32'hFFFF_FFFF);
        wr('h0C0, 32'h0000_00F0);
        wr('h0C0, 32'h0000_0001);
        rd('h0C0, d); chk("R2 mask set", d, 32'h0000_00F1);
        wr('h100, 32'h0000_0010);
        rd('h0C0, d); chk("R2 mask clear", d, 32'h0000_00E1);
        rd('h100, d); chk("R3 clear bank reads 0", d, 0);
        wr('h100, 32'hFFFF_FFFF);
        // R1 second word addressing: line 35
        wr('h1C0, 32'hFFFF_FFFF);
        wr('h184, 32'h0000_0008);
        rd('h184, d); chk("R1 sens word1", d, 32'h0000_0008);
        rd('h180, d); chk("R1 sens word0", d, 0);
        wr('h1C4, 32'hFFFF_FFFF);

        // Rising-edge mode everywhere, enable off
        wr('h300, 0);
        wr('h240, 32'hFFFF_FFFF);
        wr('h244, 32'hFFFF_FFFF);
        irq_in = '0; waitc(6); ack_all();

        // R11 synchronizer latency on line 12
        @(negedge clk) irq_in[12] = 1'b1;
        @(posedge clk); @(posedge clk);
        bus_addr = AW'('h040);
        #1 chk("R11 not yet after 2 edges", 32'(bus_rdata[12]), 0);
        @(posedge clk);
        #1 chk("R11 recorded after 3 edges", 32'(bus_rdata[12]), 1);
        irq_in[12] = 1'b0; waitc(6);

        // R8 ack of one line keeps others
        ack_all();
        irq_in[3] = 1; irq_in[35] = 1; waitc(6);
        irq_in[3] = 0; irq_in[35] = 0; waitc(6);
        wr('h040, 32'h0000_0008);
        rd('h040, d); chk("R8 ack word0", d, 0);
        rd('h044, d); chk("R1 R8 word1 kept", d, 32'h0000_0008);

        // R9 R10 flush
        ack_all();
        irq_in[2] = 1; irq_in[9] = 1; irq_in[33] = 1; irq_in[60] = 1; waitc(6);
        irq_in = '0; waitc(6);
        rd('h040, d); chk("R1 status word0", d, 32'h0000_0204);
        rd('h044, d); chk("R1 status word1", d, 32'h1000_0002);
        pulse_cnt = 0; multi = 0;
        wr('h300, 32'h5);
        rd('h300, d); chk("R10 flush busy", d, 32'h5);
        waitc(N + 6);
        rd('h300, d); chk("R10 flush self-clears", d, 32'h1);
        chk("R9 pulse count", pulse_cnt, 4);
        chk("R9 single line per cycle", multi, 0);
        chk("R9 order 0", pulse_log[0], 2);
        chk("R9 order 1", pulse_log[1], 9);
        chk("R9 order 2", pulse_log[2], 33);
        chk("R9 order 3", pulse_log[3], 60);
        rd('h040, d); chk("R9 word0 cleared", d, 0);
        rd('h044, d); chk("R9 word1 cleared", d, 0);

        // R10 flush without enable ignored
        irq_in[7] = 1; waitc(6); irq_in[7] = 0; waitc(6);
        pulse_cnt = 0;
        wr('h300, 32'h4);
        rd('h300, d); chk("R10 no flush without enable", d, 0);
        waitc(N + 6);
        chk("R10 no pulses", pulse_cnt, 0);
        rd('h040, d); chk("R10 status kept", d, 32'h0000_0080);

        // R3 reset in mid-run
        wr('h0C0, 32'h0000_0F00);
        wr('h300, 32'h3);
        @(negedge clk) rst_n = 0;
        waitc(3);
        rst_n = 1;
        rd('h0C0, d); chk("R3 reset clears mask", d, 0);
        rd('h300, d); chk("R3 reset clears ctrl", d, 0);
        rd('h040, d); chk("R3 reset clears status", d, 0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule